// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block writes one 32-byte page into a flash array and confirms the result. Software or a host engine fills a 32-byte source buffer through a byte-wide load port and then strikes a start strobe with the page address. The sequencer then walks the flash control lines (array write enable, program setup, program pulse, program-verify) through a fixed order, with every delay taken as a cycle count from a parameter. The delays therefore scale with the clock frequency.

After each program pulse the page is read back one 32-bit word at a time. An all-ones dummy write to the same address comes before each read. From the readback the block builds a fresh rewrite image: bits that already read as programmed are masked to one, so they never get another pulse. Bits that still read as erased but should be zero stay at zero for the next pulse. The loop ends with a done flag when every word matches the source. It ends with a fail flag when the pulse budget is spent.

Top module: `flash_pv_seq`

## Requirements
- R1: A start whose address has nonzero bits in positions 4..0 is refused. `fail_o` is high in the cycle after the strobe, `busy_o` stays low, and no flash control line or flash strobe is raised.
- R2: While `busy_o` is high, `start_i` and the load port have no effect on the operation in progress or on later ones.
- R3: A byte position that has not been loaded since the last operation ended is written as 0xFF. The source buffer returns to all 0xFF when an operation ends. Byte k of the page sits in word k/4, bits 8*(k%4)+7..8*(k%4).
- R4: Write enable is high whenever program setup is high. The program pulse only rises while program setup is already high. Program-verify is never high together with program setup.
- R5: Every pass first moves the 8 rewrite words to the flash, with write enable high and program-verify low, in word order 0..7, at addresses page+4*k.
- R6: With program-verify high, each of the 8 words gets a write of 0xFFFFFFFF to its address, then a read of that same address. Exactly 8 reads happen per pass.
- R7: The rewrite bit is source OR NOT verify. A bit that reads as programmed is never pulsed again, and a bit that should be 0 but reads 1 is pulsed on the next pass. The first pass uses the source itself.
- R8: When all 8 readback words equal the source words, the block raises `done_o`, drops `busy_o` and clears write enable. The pass count is the smallest number of pulses that makes every target bit read as programmed.
- R9: If the page still mismatches after MAX_PASS pulses, the block raises `fail_o`, drops `busy_o` and clears write enable. Exactly MAX_PASS pulses are issued.
- R10: The program pulse stays high for exactly T_PULSE clock cycles on every pass.
- R11: After reset `busy_o`, `done_o` and `fail_o` are low. `done_o` and `fail_o` hold their value until the next start strobe given while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| addr_i | input | AW | Byte address of the page |
| ld_en_i | input | 1 | Load one source byte |
| ld_idx_i | input | 5 | Byte position in the page |
| ld_data_i | input | 8 | Byte value to load |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Page programmed and verified |
| fail_o | output | 1 | Refused start or pulse budget exhausted |
| wr_en_o | output | 1 | Array write enable |
| prg_setup_o | output | 1 | Program setup |
| prg_pulse_o | output | 1 | Program pulse |
| prg_verify_o | output | 1 | Program-verify mode |
| fl_we_o | output | 1 | Flash word write strobe |
| fl_re_o | output | 1 | Flash word read strobe, data valid the following cycle |
| fl_addr_o | output | AW | Flash byte address of the word |
| fl_wdata_o | output | 32 | Flash write data |
| fl_rdata_i | input | 32 | Flash read data |

## Verification
The main function is swept over four data patterns on both pages of a small array model: all zeros, all ones, alternating 0x55/0xAA bytes and a pseudo-random byte ramp. This runs at three cell strengths, where each bit needs between one and K pulses. The all-zeros pattern exposes a wrong pass count, because the slowest cell anywhere in the page decides it. The all-ones pattern separates the "no bits to program" path from a real pulse. The alternating and random patterns catch lane or word-order mistakes and any re-pulse of a bit that is already programmed, which the model counts. A weak all-zeros page drives the budget-exhaustion path. Partial loads, loads and starts during a busy operation, and a misaligned start test the buffer fill, the ignore rules and the refusal path.

// File: rtl/flash_pv_pkg.sv
package flash_pv_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_SWE,
    S_XFER,
    S_PSU,
    S_PUL,
    S_PHOLD,
    S_PSUH,
    S_PVON,
    S_DUMMY,
    S_DWAIT,
    S_RD,
    S_CAP,
    S_PVOFF
  } seq_st_e;
endpackage

// File: rtl/flash_pv_timer.sv
module flash_pv_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [TW-1:0] ld_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (ld_i)        cnt_q <= ld_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_pv_passcnt.sv
module flash_pv_passcnt #(
  parameter int MAX_PASS = 400,
  localparam int PCW = $clog2(MAX_PASS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           inc_i,
  output logic [PCW-1:0] cnt_o,
  output logic           at_max_o
);
  logic [PCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= PCW'(1);
    else if (clr_i)  cnt_q <= PCW'(1);
    else if (inc_i && cnt_q < PCW'(MAX_PASS)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q >= PCW'(MAX_PASS));
endmodule

// File: rtl/flash_pv_pagebuf.sv
module flash_pv_pagebuf #(
  parameter int PAGE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int WORDS = PAGE_BYTES / WORD_BYTES,
  localparam int DW    = WORD_BYTES * 8,
  localparam int BW    = $clog2(PAGE_BYTES),
  localparam int BLW   = $clog2(WORD_BYTES),
  localparam int IW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [BW-1:0] ld_idx_i,
  input  logic [7:0]    ld_data_i,
  input  logic          clr_i,
  input  logic          init_rw_i,
  input  logic          upd_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] vdata_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] rw_o
);
  logic [DW-1:0] src_q [WORDS];
  logic [DW-1:0] rw_q  [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[w] <= '1;
      end else if (clr_i) begin
        src_q[w] <= '1;
      end else if (ld_en_i && ld_idx_i[BW-1:BLW] == IW'(w)) begin
        src_q[w][ld_idx_i[BLW-1:0]*8 +: 8] <= ld_data_i;
      end
    end

    // programmed bits (verify 0) are masked to 1: no further pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            rw_q[w] <= '1;
      else if (init_rw_i)                     rw_q[w] <= src_q[w];
      else if (upd_i && idx_i == IW'(w))      rw_q[w] <= src_q[w] | ~vdata_i;
    end
  end

  assign src_o = src_q[idx_i];
  assign rw_o  = rw_q[idx_i];
endmodule

// File: rtl/flash_pv_seq.sv
module flash_pv_seq
  import flash_pv_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 32,
  parameter int MAX_PASS   = 400,
  parameter int TW         = 16,
  parameter int T_SWE      = 1000,
  parameter int T_PSU      = 5000,
  parameter int T_PULSE    = 50000,
  parameter int T_PHOLD    = 1000,
  parameter int T_PSUH     = 1000,
  parameter int T_PV       = 400,
  parameter int T_DUMMY    = 200,
  localparam int WORD_BYTES = 4,
  localparam int WORDS = PAGE_BYTES / WORD_BYTES,
  localparam int DW    = WORD_BYTES * 8,
  localparam int BW    = $clog2(PAGE_BYTES),
  localparam int BLW   = $clog2(WORD_BYTES),
  localparam int IW    = $clog2(WORDS),
  localparam int PCW   = $clog2(MAX_PASS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ld_en_i,
  input  logic [BW-1:0] ld_idx_i,
  input  logic [7:0]    ld_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          wr_en_o,
  output logic          prg_setup_o,
  output logic          prg_pulse_o,
  output logic          prg_verify_o,
  output logic          fl_we_o,
  output logic          fl_re_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  input  logic [DW-1:0] fl_rdata_i
);
  seq_st_e st_q, st_d;
  logic [IW-1:0]    widx_q;
  logic [AW-BW-1:0] page_q;
  logic             mism_q, done_q, fail_q;
  logic             go, bad_start, ok_end, bad_end, retry, cap;
  logic             tmr_zero, tmr_ld;
  logic [TW-1:0]    wsel;
  logic [DW-1:0]    src_w, rw_w;
  logic [PCW-1:0]   pass_cnt;
  logic             at_max;
  logic             aligned;

  assign aligned = (addr_i[BW-1:0] == '0);

  always_comb begin
    st_d = st_q;
    go = 1'b0; bad_start = 1'b0; ok_end = 1'b0; bad_end = 1'b0; retry = 1'b0;
    unique case (st_q)
      S_IDLE:  if (start_i) begin
                 if (aligned) begin go = 1'b1; st_d = S_SWE; end
                 else bad_start = 1'b1;
               end
      S_SWE:   if (tmr_zero) st_d = S_XFER;
      S_XFER:  if (widx_q == IW'(WORDS - 1)) st_d = S_PSU;
      S_PSU:   if (tmr_zero) st_d = S_PUL;
      S_PUL:   if (tmr_zero) st_d = S_PHOLD;
      S_PHOLD: if (tmr_zero) st_d = S_PSUH;
      S_PSUH:  if (tmr_zero) st_d = S_PVON;
      S_PVON:  if (tmr_zero) st_d = S_DUMMY;
      S_DUMMY: st_d = S_DWAIT;
      S_DWAIT: if (tmr_zero) st_d = S_RD;
      S_RD:    st_d = S_CAP;
      S_CAP:   st_d = (widx_q == IW'(WORDS - 1)) ? S_PVOFF : S_DUMMY;
      S_PVOFF: begin
                 if (!mism_q)     begin ok_end  = 1'b1; st_d = S_IDLE; end
                 else if (at_max) begin bad_end = 1'b1; st_d = S_IDLE; end
                 else             begin retry   = 1'b1; st_d = S_XFER; end
               end
      default: st_d = S_IDLE;
    endcase
  end

  assign cap = (st_q == S_CAP);

  always_comb begin
    unique case (st_d)
      S_SWE:   wsel = TW'(T_SWE);
      S_PSU:   wsel = TW'(T_PSU);
      S_PUL:   wsel = TW'(T_PULSE);
      S_PHOLD: wsel = TW'(T_PHOLD);
      S_PSUH:  wsel = TW'(T_PSUH);
      S_PVON:  wsel = TW'(T_PV);
      S_DWAIT: wsel = TW'(T_DUMMY);
      default: wsel = TW'(1);
    endcase
  end

  assign tmr_ld = (st_d != st_q);

  flash_pv_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (tmr_ld),
    .ld_val_i (wsel - 1'b1),
    .zero_o   (tmr_zero)
  );

  flash_pv_passcnt #(.MAX_PASS(MAX_PASS)) u_pass (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (go),
    .inc_i    (retry),
    .cnt_o    (pass_cnt),
    .at_max_o (at_max)
  );

  flash_pv_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (ld_en_i && st_q == S_IDLE),
    .ld_idx_i  (ld_idx_i),
    .ld_data_i (ld_data_i),
    .clr_i     (ok_end || bad_end),
    .init_rw_i (go),
    .upd_i     (cap),
    .idx_i     (widx_q),
    .vdata_i   (fl_rdata_i),
    .src_o     (src_w),
    .rw_o      (rw_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      widx_q <= '0;
      page_q <= '0;
      mism_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (go) begin
        page_q <= addr_i[AW-1:BW];
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (bad_start) begin
        done_q <= 1'b0;
        fail_q <= 1'b1;
      end
      if (ok_end)  done_q <= 1'b1;
      if (bad_end) fail_q <= 1'b1;
      if (go || retry || st_q == S_PVON) widx_q <= '0;
      else if (st_q == S_XFER || cap)    widx_q <= widx_q + 1'b1;
      if (st_q == S_PVON)  mism_q <= 1'b0;
      else if (cap && fl_rdata_i != src_w) mism_q <= 1'b1;
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign wr_en_o      = (st_q != S_IDLE);
  assign prg_setup_o  = (st_q == S_PSU) || (st_q == S_PUL) || (st_q == S_PHOLD);
  assign prg_pulse_o  = (st_q == S_PUL);
  assign prg_verify_o = (st_q == S_PVON) || (st_q == S_DUMMY) || (st_q == S_DWAIT) ||
                        (st_q == S_RD)   || (st_q == S_CAP);
  assign fl_we_o      = (st_q == S_XFER) || (st_q == S_DUMMY);
  assign fl_re_o      = (st_q == S_RD);
  assign fl_addr_o    = {page_q, widx_q, BLW'(0)};
  assign fl_wdata_o   = (st_q == S_DUMMY) ? '1 : rw_w;
endmodule

// File: rtl/flash_pv_seq_chk.sv
module flash_pv_seq_chk #(
  parameter int BW       = 5,
  parameter int MAX_PASS = 400,
  parameter int DW       = 32,
  localparam int PCW     = $clog2(MAX_PASS + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [BW-1:0]  addr_lo_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           fail_o,
  input logic           wr_en_o,
  input logic           prg_setup_o,
  input logic           prg_pulse_o,
  input logic           prg_verify_o,
  input logic           fl_we_o,
  input logic           fl_re_o,
  input logic [DW-1:0]  fl_wdata_o,
  input logic [PCW-1:0] pass_cnt_i
);
  a_r1_misaligned_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && addr_lo_i != '0) |=> (fail_o && !busy_o && !wr_en_o));

  a_r4_pulse_in_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_pulse_o |-> (prg_setup_o && wr_en_o));

  a_r4_setup_needs_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_setup_o |-> wr_en_o);

  a_r4_pulse_after_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prg_pulse_o) |-> $past(prg_setup_o));

  a_r4_verify_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prg_verify_o && prg_setup_o));

  a_r6_dummy_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && prg_verify_o) |-> (&fl_wdata_o));

  a_r6_read_in_verify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_re_o |-> prg_verify_o);

  a_r9_pass_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_cnt_i >= PCW'(1)) && (pass_cnt_i <= PCW'(MAX_PASS)));

  a_r8_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!wr_en_o && !fl_we_o && !fl_re_o));

  a_r11_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && done_o) |=> done_o);
endmodule

bind flash_pv_seq flash_pv_seq_chk #(
  .BW(BW), .MAX_PASS(MAX_PASS), .DW(DW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .addr_lo_i    (addr_i[BW-1:0]),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .wr_en_o      (wr_en_o),
  .prg_setup_o  (prg_setup_o),
  .prg_pulse_o  (prg_pulse_o),
  .prg_verify_o (prg_verify_o),
  .fl_we_o      (fl_we_o),
  .fl_re_o      (fl_re_o),
  .fl_wdata_o   (fl_wdata_o),
  .pass_cnt_i   (pass_cnt)
);

// File: tb/flash_pv_seq_tb_top.sv
module flash_pv_seq_tb_top;
  localparam int AW = 8;
  localparam int MAXP = 6;
  localparam int TPUL = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        ld_en_i = 1'b0;
  logic [4:0]  ld_idx_i = '0;
  logic [7:0]  ld_data_i = '0;
  logic        busy_o, done_o, fail_o;
  logic        wr_en_o, prg_setup_o, prg_pulse_o, prg_verify_o;
  logic        fl_we_o, fl_re_o;
  logic [7:0]  fl_addr_o;
  logic [31:0] fl_wdata_o;
  logic [31:0] fl_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  flash_pv_seq #(
    .AW(AW), .PAGE_BYTES(32), .MAX_PASS(MAXP), .TW(8),
    .T_SWE(2), .T_PSU(3), .T_PULSE(TPUL), .T_PHOLD(2), .T_PSUH(2), .T_PV(2), .T_DUMMY(2)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .wr_en_o(wr_en_o), .prg_setup_o(prg_setup_o), .prg_pulse_o(prg_pulse_o),
    .prg_verify_o(prg_verify_o), .fl_we_o(fl_we_o), .fl_re_o(fl_re_o),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata_i)
  );

  // behavioural flash: 2 pages, each bit needs need() pulses to program
  logic [31:0] mem [16];
  logic [31:0] latch [8];
  int hits [16][32];
  int kmax = 1;
  int pulses, viol, dum_bad, pw_bad, xfer_bad, ord_bad, rds, xfers, we_seen, phigh, xexp;
  logic p_q = 1'b0, dvalid = 1'b0, lpg = 1'b0;
  logic [7:0] last_dummy = '0;
  int n_tests = 0, n_fail = 0;

  function automatic int need(int mi, int b);
    return 1 + ((mi * 32 + b) * 7) % kmax;
  endfunction

  always @(posedge clk_i) begin
    if (wr_en_o) we_seen++;
    if (prg_setup_o && !wr_en_o) ord_bad++;
    if (prg_pulse_o && !p_q && (!prg_setup_o || prg_verify_o)) ord_bad++;
    if (prg_pulse_o) phigh++;
    if (p_q && !prg_pulse_o) begin
      if (phigh != TPUL) pw_bad++;
      phigh = 0;
      pulses++;
      for (int w = 0; w < 8; w++)
        for (int b = 0; b < 32; b++) begin
          int mi;
          mi = int'(lpg) * 8 + w;
          if (!latch[w][b]) begin
            if (!mem[mi][b]) viol++;
            else begin
              hits[mi][b]++;
              if (hits[mi][b] >= need(mi, b)) mem[mi][b] = 1'b0;
            end
          end
        end
    end
    p_q = prg_pulse_o;
    if (fl_we_o && !prg_verify_o) begin
      if (int'(fl_addr_o[4:2]) != xexp) xfer_bad++;
      xexp = (xexp + 1) % 8;
      latch[fl_addr_o[4:2]] = fl_wdata_o;
      lpg = fl_addr_o[5];
      xfers++;
    end
    if (fl_we_o && prg_verify_o) begin
      if (fl_wdata_o != 32'hFFFF_FFFF) dum_bad++;
      last_dummy = fl_addr_o;
      dvalid = 1'b1;
    end
    if (fl_re_o) begin
      if (!dvalid || last_dummy != fl_addr_o) dum_bad++;
      dvalid = 1'b0;
      rds++;
      fl_rdata_i <= mem[fl_addr_o[5:2]];
    end
  end

  task automatic chk(input logic c, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic erase_all();
    for (int i = 0; i < 16; i++) begin
      mem[i] = '1;
      for (int b = 0; b < 32; b++) hits[i][b] = 0;
    end
  endtask

  task automatic clr_stats();
    pulses = 0; viol = 0; dum_bad = 0; pw_bad = 0; xfer_bad = 0; ord_bad = 0;
    rds = 0; xfers = 0; we_seen = 0; xexp = 0;
  endtask

  task automatic load_byte(input int idx, input logic [7:0] d);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_idx_i = 5'(idx); ld_data_i = d;
    @(negedge clk_i);
    ld_en_i = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] a);
    @(negedge clk_i);
    start_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
  endtask

  function automatic logic [7:0] pat(int p, int i);
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return i[0] ? 8'h55 : 8'hAA;
      default: return 8'((i * 37 + 11) & 255);
    endcase
  endfunction

  function automatic int exp_pulses(int pg, int p);
    int m = 1;
    for (int i = 0; i < 32; i++)
      for (int b = 0; b < 8; b++)
        if (!pat(p, i)[b] && need(pg * 8 + i / 4, (i % 4) * 8 + b) > m)
          m = need(pg * 8 + i / 4, (i % 4) * 8 + b);
    return m;
  endfunction

  initial begin : wdog
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    erase_all();
    clr_stats();
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !fail_o, "R11 reset flags", {busy_o, done_o, fail_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: misaligned start
    clr_stats();
    @(negedge clk_i); start_i = 1'b1; addr_i = 8'h24;
    @(negedge clk_i); start_i = 1'b0;
    chk(fail_o && !busy_o, "R1 refuse flags", {fail_o, busy_o}, 2'b10);
    repeat (4) @(negedge clk_i);
    chk(we_seen == 0 && xfers == 0, "R1 no control", we_seen + xfers, 0);

    // R7 R8 R5 R6 R10 sweep: strengths x patterns x pages
    foreach (kmax_list[k]) begin
      for (int p = 0; p < 4; p++) begin
        int pg, ep;
        bit mem_ok;
        kmax = kmax_list[k];
        pg = (k + p) % 2;
        erase_all();
        clr_stats();
        for (int i = 0; i < 32; i++) load_byte(i, pat(p, i));
        ep = exp_pulses(pg, p);
        run_op(8'(pg * 32));
        chk(done_o && !fail_o && !wr_en_o, "R8 done", {done_o, fail_o}, 2'b10);
        chk(pulses == ep, "R8 pass count", pulses, ep);
        mem_ok = 1;
        for (int w = 0; w < 8; w++)
          if (mem[pg * 8 + w] != {pat(p, 4*w+3), pat(p, 4*w+2), pat(p, 4*w+1), pat(p, 4*w)}) mem_ok = 0;
        chk(mem_ok, "R7 page content", mem_ok, 1);
        chk(viol == 0, "R7 no repulse", viol, 0);
        chk(xfers == 8 * ep && xfer_bad == 0, "R5 transfer order", xfers, 8 * ep);
        chk(rds == 8 * ep && dum_bad == 0, "R6 dummy then read", rds, 8 * ep);
        chk(pw_bad == 0 && ord_bad == 0, "R10 R4 pulse width/order", pw_bad + ord_bad, 0);
      end
    end

    // R9: weak page exhausts budget
    kmax = 9;
    erase_all();
    clr_stats();
    for (int i = 0; i < 32; i++) load_byte(i, 8'h00);
    run_op(8'h00);
    chk(fail_o && !done_o && !busy_o && !wr_en_o, "R9 fail flags", {fail_o, done_o}, 2'b10);
    chk(pulses == MAXP, "R9 pulse budget", pulses, MAXP);
    chk(viol == 0, "R7 no repulse under retry", viol, 0);

    // R3: partial load, unused bytes 0xFF
    kmax = 1;
    erase_all();
    clr_stats();
    load_byte(0, 8'h12); load_byte(1, 8'h34); load_byte(2, 8'h56); load_byte(3, 8'h78);
    run_op(8'h20);
    chk(mem[8] == 32'h7856_3412, "R3 loaded word", mem[8], 32'h7856_3412);
    chk(mem[9] == '1 && mem[15] == '1, "R3 unused bytes 0xFF", mem[9], 32'hFFFF_FFFF);

    // R3: buffer cleared after operation
    clr_stats();
    run_op(8'h00);
    chk(done_o && mem[0] == '1 && pulses == 1, "R3 cleared buffer", mem[0], 32'hFFFF_FFFF);

    // R2: start and load ignored while busy
    erase_all();
    clr_stats();
    load_byte(0, 8'h0F);
    @(negedge clk_i); start_i = 1'b1; addr_i = 8'h00;
    @(negedge clk_i); start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    start_i = 1'b1; addr_i = 8'h24; ld_en_i = 1'b1; ld_idx_i = 5'd1; ld_data_i = 8'h00;
    @(negedge clk_i);
    start_i = 1'b0; ld_en_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    chk(done_o && !fail_o, "R2 busy start ignored", {done_o, fail_o}, 2'b10);
    chk(mem[0] == 32'hFFFF_FF0F, "R2 busy load ignored", mem[0], 32'hFFFF_FF0F);

    // R11: done held, cleared by next start
    repeat (5) @(negedge clk_i);
    chk(done_o, "R11 done held", done_o, 1);
    @(negedge clk_i); start_i = 1'b1; addr_i = 8'h01;
    @(negedge clk_i); start_i = 1'b0;
    chk(!done_o && fail_o, "R11 cleared by start", {done_o, fail_o}, 2'b01);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int kmax_list [3] = '{1, 2, 4};
endmodule